// File: doc/BRIEF.md
# Run-Time Programmable Serial CRC Unit

This block divides a serial bit stream, most significant bit first, by a divisor pattern that is chosen at run time. In generate mode it takes a message of k bits and forwards each bit to its output. It then appends n check bits, so the (k+n)-bit frame on the output divides exactly by the divisor. In check mode it divides a received frame of any length and raises an error flag when the remainder is not zero.

The divisor is given as up to 16 low coefficients plus a degree setting n. The leading coefficient x^n is always taken as one. Frames are delimited by start and end markers on the valid input bits. While the check bits are being appended, the block drops its ready signal and ignores its input. Divisor, degree and mode must not change while a frame is in progress.

Top module: `crc_serial_unit`

## Requirements
- R1: In generate mode (mode_i = 0 at the start bit) each accepted bit appears on out_bit with out_valid one cycle later. After the end bit, the n remainder bits follow most significant first, so out_valid stays high for exactly k+n consecutive cycles.
- R2: The appended bits equal (M(x)·x^n) mod P(x), kept at the full n-bit width including leading zeros. For message 1010001101 and divisor 110101 they are 01110, giving the frame 101000110101110.
- R3: Bit i of poly_i (i < n) is the coefficient of x^i. The x^n coefficient is always one, and poly_i bits at n and above are ignored. deg_i selects n: a value of 0 acts as 1, and a value above MAX_DEG acts as MAX_DEG.
- R4: In check mode (mode_i = 1 at the start bit) chk_done pulses for one cycle, one cycle after the end bit is accepted. chk_err is 1 in that cycle exactly when the frame leaves a nonzero remainder modulo P. No bit is output in check mode. Every generated frame passes, and any single flipped bit is flagged.
- R5: in_ready is low for the n append cycles after a generate-mode end bit, and all input in those cycles is ignored.
- R6: Valid bits that arrive outside a frame (after an end bit and before the next start bit) are ignored.
- R7: A start bit clears the remainder, so a new start bit in the middle of a frame restarts the division.
- R8: The mode is taken at the start bit. Changes to mode_i later in the frame have no effect.
- R9: After reset, in_ready = 1 and out_valid, chk_done and chk_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = generate, 1 = check; taken at the start bit |
| poly_i | input | MAX_DEG+1 | Divisor coefficients, bit i = x^i |
| deg_i | input | $clog2(MAX_DEG+1) | Divisor degree n |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Serial input bit |
| in_sof | input | 1 | First bit of a frame |
| in_eof | input | 1 | Last bit of a frame |
| in_ready | output | 1 | Input accepted this cycle |
| out_valid | output | 1 | Output bit is valid |
| out_bit | output | 1 | Serial output bit |
| chk_done | output | 1 | Check-mode result strobe |
| chk_err | output | 1 | Nonzero remainder, valid with chk_done |

## Verification
The bench builds the block with the default MAX_DEG of 16, so it can exercise degree 1 (plain parity), degree 5, and the full 16-bit degree together with the clamping of out-of-range degree settings. With the degree-5 divisor, small messages can be swept exhaustively: every message of 1 to 8 bits is generated and then re-checked. Every single-bit corruption of every 8-bit-message frame is then fed back through check mode.

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int MAX_DEG = 16,
  localparam int DW = $clog2(MAX_DEG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_i,
  input  logic [MAX_DEG:0]   poly_i,
  input  logic [DW-1:0]      deg_i,
  input  logic               in_valid,
  input  logic               in_bit,
  input  logic               in_sof,
  input  logic               in_eof,
  output logic               in_ready,
  output logic               out_valid,
  output logic               out_bit,
  output logic               chk_done,
  output logic               chk_err
);

  localparam int W = MAX_DEG;

  logic [W-1:0]  rem, base, shifted, nxt, mask, top;
  logic [DW-1:0] n_eff, cnt;
  logic          busy, in_frame, mode_q, cur_mode, acc, fb;

  always_comb begin
    if (deg_i == '0)                 n_eff = DW'(1);
    else if (deg_i > DW'(MAX_DEG))   n_eff = DW'(MAX_DEG);
    else                             n_eff = deg_i;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      mask[i] = (i < int'(n_eff));
      top[i]  = (i == int'(n_eff) - 1);
    end
  end

  assign in_ready = !busy;
  assign acc      = in_valid && !busy && (in_sof || in_frame);
  assign cur_mode = in_sof ? mode_i : mode_q;
  assign base     = in_sof ? '0 : rem;
  assign fb       = (|(base & top)) ^ (cur_mode ? 1'b0 : in_bit);
  assign shifted  = {base[W-2:0], cur_mode ? in_bit : 1'b0};
  assign nxt      = (shifted ^ (fb ? poly_i[W-1:0] : '0)) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; cnt <= '0; busy <= 1'b0; in_frame <= 1'b0; mode_q <= 1'b0;
      out_valid <= 1'b0; out_bit <= 1'b0; chk_done <= 1'b0; chk_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      chk_done  <= 1'b0;
      chk_err   <= 1'b0;
      if (busy) begin
        out_valid <= 1'b1;
        out_bit   <= |(rem & top);
        rem       <= {rem[W-2:0], 1'b0} & mask;
        cnt       <= cnt - 1'b1;
        if (cnt == DW'(1)) busy <= 1'b0;
      end else if (acc) begin
        rem      <= nxt;
        mode_q   <= cur_mode;
        in_frame <= !in_eof;
        if (!cur_mode) begin
          out_valid <= 1'b1;
          out_bit   <= in_bit;
        end
        if (in_eof) begin
          if (!cur_mode) begin
            busy <= 1'b1;
            cnt  <= n_eff;
          end else begin
            chk_done <= 1'b1;
            chk_err  <= (nxt != '0);
          end
        end
      end
    end
  end

  // R1
  append_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_eof && !cur_mode) |=> (busy && out_valid));

  // R1
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(busy) || $past(acc && !cur_mode)));

  // R2
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == DW'(1)) |=> (rem == '0));

  // R4
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $past(acc && in_eof && cur_mode));

  // R4
  err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> chk_done);

  // R5
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_eof));

endmodule

// File: tb/sim_crc_serial_unit.sv
`timescale 1ns/1ps
module sim_crc_serial_unit;
  localparam int MD = 16;
  localparam int DW = $clog2(MD + 1);

  logic clk = 0, rst_n = 0;
  logic mode_i = 0, in_valid = 0, in_bit = 0, in_sof = 0, in_eof = 0;
  logic [MD:0] poly_i = '0;
  logic [DW-1:0] deg_i = '0;
  logic in_ready, out_valid, out_bit, chk_done, chk_err;

  crc_serial_unit #(.MAX_DEG(MD)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .poly_i(poly_i), .deg_i(deg_i),
    .in_valid(in_valid), .in_bit(in_bit), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .chk_done(chk_done), .chk_err(chk_err));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [127:0] cap_word = '0;
  int cap_n = 0, done_cnt = 0;
  logic last_err = 0;
  logic [63:0] cur_poly = '0;
  int cur_n = 1;

  always @(negedge clk) begin
    if (out_valid) begin cap_word = {cap_word[126:0], out_bit}; cap_n++; end
    if (chk_done) begin done_cnt++; last_err = chk_err; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modp(input logic [63:0] v, input int len);
    logic [63:0] full, msk;
    msk  = (64'd1 << cur_n) - 64'd1;
    full = (cur_poly & msk) | (64'd1 << cur_n);
    for (int b = len - 1; b >= cur_n; b--)
      if (v[b]) v = v ^ (full << (b - cur_n));
    return v & msk;
  endfunction

  task automatic set_div(input logic [63:0] p, input int n);
    cur_poly = p; cur_n = n;
    poly_i = p[MD:0]; deg_i = DW'(n);
  endtask

  task automatic clr;
    cap_word = '0; cap_n = 0; done_cnt = 0; last_err = 0;
  endtask

  task automatic drive(input bit md, input bit md_rest, input logic [63:0] bits,
                       input int len, input bit close, input int hold_busy);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_bit = bits[len-1-i]; in_sof = (i == 0);
      in_eof = close && (i == len - 1); mode_i = (i == 0) ? md : md_rest;
    end
    for (int i = 0; i < hold_busy; i++) begin
      @(negedge clk);
      in_valid = 1; in_bit = 1; in_sof = 1; in_eof = 1; mode_i = 1;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_bit = 0;
    repeat (cur_n + 3) @(negedge clk);
  endtask

  task automatic gen_case(input logic [63:0] msg, input int k, input string req);
    logic [63:0] frm;
    frm = (msg << cur_n) | modp(msg << cur_n, k + cur_n);
    clr; drive(0, 0, msg, k, 1, 0);
    chk(cap_n == k + cur_n && cap_word[63:0] == frm, req, cap_word[63:0], frm);
    clr; drive(1, 1, frm, k + cur_n, 1, 0);
    chk(done_cnt == 1 && !last_err && cap_n == 0, "R4 pass", {last_err, 31'd0, 32'(done_cnt)}, 64'd1);
  endtask

  initial begin
    logic [63:0] frm, bad, e;
    #5000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] frm, bad, e, r16;
    set_div(64'b110101, 5);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready && !out_valid && !chk_done && !chk_err, "R9",
        {in_ready, out_valid, chk_done, chk_err}, 64'h8);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 worked example
    clr; drive(0, 0, 64'b1010001101, 10, 1, 0);
    chk(cap_n == 15 && cap_word[63:0] == 64'b101000110101110, "R2 example",
        cap_word[63:0], 64'b101000110101110);

    // R1 R4 exhaustive sweep, degree 5
    for (int k = 1; k <= 8; k++)
      for (int m = 0; m < (1 << k); m++)
        gen_case(64'(m), k, "R1 sweep");

    // R4 single-bit corruption of every 8-bit frame
    for (int m = 0; m < 256; m++) begin
      frm = (64'(m) << 5) | modp(64'(m) << 5, 13);
      for (int j = 0; j < 13; j++) begin
        bad = frm ^ (64'd1 << j);
        clr; drive(1, 1, bad, 13, 1, 0);
        chk(done_cnt == 1 && last_err && modp(bad, 13) != 0, "R4 flip",
            {last_err, 31'd0, 32'(done_cnt)}, 64'h8000000000000001);
      end
    end

    // R3 bits at and above n ignored
    set_div(64'b110101, 5);
    poly_i = 17'h1FFE0 | 17'b10101;
    clr; drive(0, 0, 64'b1010001101, 10, 1, 0);
    chk(cap_word[63:0] == 64'b101000110101110, "R3 high bits", cap_word[63:0], 64'b101000110101110);

    // R3 degree 0 acts as 1 (parity)
    set_div(64'h1, 1); deg_i = '0;
    clr; drive(0, 0, 64'b1011, 4, 1, 0);
    chk(cap_n == 5 && cap_word[63:0] == 64'b10111, "R3 deg0", cap_word[63:0], 64'b10111);

    // R3 full degree 16 and clamp above MAX_DEG
    set_div(64'h1021, 16);
    r16 = (64'h3132 << 16) | modp(64'h3132 << 16, 32);
    gen_case(64'h3132, 16, "R3 deg16");
    deg_i = '1;
    clr; drive(0, 0, 64'h3132, 16, 1, 0);
    chk(cap_n == 32 && cap_word[63:0] == r16, "R3 clamp", cap_word[63:0], r16);

    // R3 divisor with zero constant term
    set_div(64'b010100, 5);
    gen_case(64'b11001101, 8, "R3 x-factor");

    set_div(64'b110101, 5);
    e = (64'b1101 << 5) | modp(64'b1101 << 5, 9);

    // R5 input ignored while appending
    clr; drive(0, 0, 64'b1101, 4, 1, 5);
    chk(cap_n == 9 && cap_word[63:0] == e && done_cnt == 0, "R5", cap_word[63:0], e);

    // R6 bits outside a frame ignored
    clr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1; in_bit = 1; in_sof = 0; in_eof = 0; mode_i = 0;
    end
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);
    chk(cap_n == 0, "R6 before", 64'(cap_n), 64'd0);
    drive(0, 0, 64'b1101, 4, 1, 0);
    chk(cap_word[63:0] == e, "R6 frame", cap_word[63:0], e);

    // R7 restart on a new start bit
    clr; drive(0, 0, 64'b1111, 4, 0, 0);
    clr; drive(0, 0, 64'b1101, 4, 1, 0);
    chk(cap_n == 9 && cap_word[63:0] == e, "R7", cap_word[63:0], e);

    // R8 mode change after start ignored
    clr; drive(0, 1, 64'b1101, 4, 1, 0);
    chk(cap_n == 9 && cap_word[63:0] == e && done_cnt == 0, "R8 gen", cap_word[63:0], e);
    clr; drive(1, 0, e ^ 64'd1, 9, 1, 0);
    chk(cap_n == 0 && done_cnt == 1 && last_err, "R8 chk", 64'(cap_n), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule